// File: doc/BRIEF.md
# Urgency-Aware DMA Channel Arbiter

This block selects one DMA requester per clock cycle and registers the grant. The requesters are a set of peripheral channels and two memory-to-memory streams. Each peripheral channel has a request line, an urgent flag and a direction bit. A lower channel index means a higher static priority. If any requesting channel is urgent, every non-urgent requester is pushed down by a fixed priority offset of 32, so only an urgent channel can win that cycle. A grant made while an urgent request is pending also raises an expedite flag for the memory transfer that follows. No configuration is needed for this.

Both memory streams rank below all peripheral traffic. They are granted only in cycles where no peripheral channel requests. A period input chooses how the two streams share bandwidth. A period of zero gives stream 0 fixed precedence. A non-zero period P lets the stream holding precedence keep it for P of its own grants, after which precedence passes to the other stream.

The outputs are registered. A request present before a clock edge produces its grant just after that edge. The grant appears as a one-hot vector, a binary index, a valid bit and the expedite flag.

Top module: `dma_urgent_arb`

## Requirements
- R1: Each grant is registered one cycle after the requests that cause it. The one-hot vector has at most one bit set, and that bit matches the index. Channel i uses bit and index i, stream 0 uses NCH and stream 1 uses NCH+1.
- R2: After reset, and in any cycle that follows a cycle with no requests, the grant is idle: valid low, one-hot all zero, index 0 and expedite low.
- R3: When at least one requesting channel has its urgent flag set, a non-urgent requester is never granted, even if its index is lower. An urgent flag on a channel that is not requesting has no effect.
- R4: When several urgent channels request, a channel whose direction bit equals the direction of the last granted peripheral channel beats a lower-indexed channel with the other direction. The remembered direction is 0 after reset.
- R5: When no urgent request is present, the same direction tie-break applies first. Among candidates with the same direction match, the lowest index wins.
- R6: The expedite flag is high exactly when the registered grant was made while at least one requesting channel was urgent.
- R7: A memory stream is granted only when no peripheral channel requests. Any peripheral request wins over both streams.
- R8: With a period of zero and both streams ready, stream 0 is granted every time.
- R9: With a non-zero period P and both streams ready, the stream holding precedence (stream 0 after reset) is granted P times in a row, and then the other stream takes precedence.
- R10: If the stream holding precedence is not ready, the other stream is granted. That grant does not advance the hand-off count.
- R11: A change of the period value clears the hand-off count and returns precedence to stream 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | NCH | Peripheral channel requests |
| ch_urgent | input | NCH | Urgent flag per channel |
| ch_dir | input | NCH | Direction bit per channel (0 or 1) |
| ms_req | input | 2 | Memory stream ready, bit 0 for stream 0 |
| rr_period | input | PW | Stream hand-off period, 0 selects fixed precedence |
| gnt_valid | output | 1 | A grant is present this cycle |
| gnt_onehot | output | NCH+2 | One-hot grant vector |
| gnt_idx | output | IW | Index of the granted requester |
| gnt_expedite | output | 1 | Mark the granted transfer for expedited handling |

## Verification
The channel selection is tried with five kinds of input: an urgent channel against a lower-indexed non-urgent one, two urgent channels with opposite directions under both remembered directions, non-urgent mixes that separate the direction tie-break from index order, and an urgent flag without a request. Together these tell a correct priority offset apart from plain index order and from a faulty urgency filter. Peripheral-against-stream contention checks the class ordering. Runs of stream grants under period zero, period three with the holder missing, and a period change in the middle of a run each expose a different fault in the hand-off counter: an off-by-one, a count on the wrong grant, or a missing clear.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int URGENT_PENALTY = 32;

  // effective static priority of one peripheral requester (lower wins)
  function automatic int eff_prio(input int idx, input logic urg, input logic any_urg);
    return idx + ((any_urg && !urg) ? URGENT_PENALTY : 0);
  endfunction

  // true when the requester lost its class because of a pending urgent request
  function automatic logic demoted(input int idx, input logic urg, input logic any_urg);
    return eff_prio(idx, urg, any_urg) >= URGENT_PENALTY;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int IW  = 4
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] urg,
  input  logic [NCH-1:0] dir,
  input  logic           last_dir,
  output logic           pick_valid,
  output logic           any_urg,
  output logic [IW-1:0]  pick_idx
);
  localparam int KW = IW + 2;

  logic [KW-1:0] best_key;
  logic [KW-1:0] key;

  always_comb begin
    any_urg    = |(req & urg);
    pick_valid = |req;
    pick_idx   = '0;
    best_key   = '1;
    key        = '1;
    for (int i = 0; i < NCH; i++) begin
      if (req[i]) begin
        // class first, then direction match, then static index
        key = {demoted(i, urg[i], any_urg), dir[i] != last_dir, IW'(i)};
        if (key < best_key) begin
          best_key = key;
          pick_idx = IW'(i);
        end
      end
    end
  end

  initial begin
    assert (NCH <= URGENT_PENALTY) else $error("NCH exceeds urgent penalty");
  end
endmodule

// File: rtl/dma_arb_mem_rr.sv
module dma_arb_mem_rr #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ms_req,
  input  logic          fire,
  input  logic [PW-1:0] period,
  output logic          ms_valid,
  output logic          ms_sel
);
  logic          holder_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_q;
  logic          per_changed;
  logic          holder_won;

  assign per_changed = (period != per_q);
  assign ms_valid    = |ms_req;

  always_comb begin
    if (period == '0) ms_sel = ms_req[0] ? 1'b0 : 1'b1;
    else              ms_sel = ms_req[holder_q] ? holder_q : ~holder_q;
  end

  assign holder_won = fire && ms_valid && (period != '0) && (ms_sel == holder_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holder_q <= 1'b0;
      cnt_q    <= '0;
      per_q    <= '0;
    end else if (per_changed) begin
      per_q    <= period;
      holder_q <= 1'b0;
      cnt_q    <= '0;
    end else if (holder_won) begin
      if (cnt_q == period - 1'b1) begin
        holder_q <= ~holder_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: the hand-off count never reaches the period
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0 && !per_changed) |-> cnt_q < period);
  // R11: a period change clears the count and returns precedence to stream 0
  a_r11_period_clear: assert property (@(posedge clk) disable iff (!rst_n)
    per_changed |=> (cnt_q == '0 && holder_q == 1'b0));
  // R10: a grant to the stream not holding precedence leaves the count alone
  a_r10_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ms_valid && !per_changed && ms_sel != holder_q) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_urgent_arb.sv
module dma_urgent_arb #(
  parameter int NCH = 8,
  parameter int PW  = 8,
  parameter int IW  = $clog2(NCH + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ch_req,
  input  logic [NCH-1:0]  ch_urgent,
  input  logic [NCH-1:0]  ch_dir,
  input  logic [1:0]      ms_req,
  input  logic [PW-1:0]   rr_period,
  output logic            gnt_valid,
  output logic [NCH+1:0]  gnt_onehot,
  output logic [IW-1:0]   gnt_idx,
  output logic            gnt_expedite
);
  localparam int GW = NCH + 2;

  function automatic logic [GW-1:0] to_onehot(input logic [IW-1:0] idx);
    logic [GW-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  logic          last_dir_q;
  logic          pick_valid, any_urg;
  logic [IW-1:0] pick_idx;
  logic          ms_valid, ms_sel;
  logic          nxt_valid;
  logic [IW-1:0] nxt_idx;

  dma_arb_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req(ch_req), .urg(ch_urgent), .dir(ch_dir), .last_dir(last_dir_q),
    .pick_valid(pick_valid), .any_urg(any_urg), .pick_idx(pick_idx)
  );

  dma_arb_mem_rr #(.PW(PW)) u_mem_rr (
    .clk(clk), .rst_n(rst_n), .ms_req(ms_req), .fire(!pick_valid),
    .period(rr_period), .ms_valid(ms_valid), .ms_sel(ms_sel)
  );

  always_comb begin
    nxt_valid = pick_valid | ms_valid;
    if (pick_valid)    nxt_idx = pick_idx;
    else if (ms_valid) nxt_idx = IW'(NCH) + IW'(ms_sel);
    else               nxt_idx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid    <= 1'b0;
      gnt_onehot   <= '0;
      gnt_idx      <= '0;
      gnt_expedite <= 1'b0;
      last_dir_q   <= 1'b0;
    end else begin
      gnt_valid    <= nxt_valid;
      gnt_onehot   <= nxt_valid ? to_onehot(nxt_idx) : '0;
      gnt_idx      <= nxt_idx;
      gnt_expedite <= pick_valid & any_urg;
      if (pick_valid) last_dir_q <= ch_dir[pick_idx];
    end
  end

  // assertion helpers: what the requesters showed at the previous edge
  logic [NCH-1:0] req_seen_q, urg_seen_q;
  logic [1:0]     ms_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_seen_q <= '0;
      urg_seen_q <= '0;
      ms_seen_q  <= '0;
    end else begin
      req_seen_q <= ch_req;
      urg_seen_q <= ch_req & ch_urgent;
      ms_seen_q  <= ms_req;
    end
  end

  // R1
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_onehot) && (gnt_valid == (gnt_onehot != '0)));
  // R2
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_seen_q == '0 && ms_seen_q == '0) |-> !gnt_valid && !gnt_expedite);
  // R3
  a_r3_urgent_only: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && urg_seen_q != '0) |-> (gnt_idx < IW'(NCH) && urg_seen_q[gnt_idx[$clog2(NCH)-1:0]]));
  // R6
  a_r6_expedite: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_expedite == (urg_seen_q != '0));
  // R7
  a_r7_streams_below: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_idx >= IW'(NCH)) |-> req_seen_q == '0);
endmodule

// File: tb/dma_urgent_arb_bench.sv
module dma_urgent_arb_bench;
  localparam int NCH = 8;
  localparam int PW  = 8;
  localparam int IW  = $clog2(NCH + 2);
  localparam int S0  = NCH;
  localparam int S1  = NCH + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_req = '0, ch_urgent = '0, ch_dir = '0;
  logic [1:0]     ms_req = '0;
  logic [PW-1:0]  rr_period = '0;
  logic           gnt_valid, gnt_expedite;
  logic [NCH+1:0] gnt_onehot;
  logic [IW-1:0]  gnt_idx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_urgent_arb #(.NCH(NCH), .PW(PW)) u_dma_urgent_arb (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_urgent(ch_urgent),
    .ch_dir(ch_dir), .ms_req(ms_req), .rr_period(rr_period),
    .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx),
    .gnt_expedite(gnt_expedite)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_gnt(input string tag, input logic ev, input int eidx, input logic eexp);
    logic [NCH+1:0] eoh;
    eoh = ev ? ((NCH+2)'(1) << eidx) : '0;
    checks++;
    if (gnt_valid !== ev || gnt_onehot !== eoh || int'(gnt_idx) != eidx || gnt_expedite !== eexp) begin
      errors++;
      $display("FAIL %s: got valid=%0b idx=%0d onehot=%b exp=%0b, expected valid=%0b idx=%0d onehot=%b exp=%0b",
               tag, gnt_valid, gnt_idx, gnt_onehot, gnt_expedite, ev, eidx, eoh, eexp);
    end
  endtask

  task automatic drive(input logic [NCH-1:0] r, input logic [NCH-1:0] u,
                       input logic [NCH-1:0] d, input logic [1:0] m);
    ch_req = r; ch_urgent = u; ch_dir = d; ms_req = m;
  endtask

  task automatic t_reset_idle();
    expect_gnt("R2 reset state", 1'b0, 0, 1'b0);
    drive('0, 8'h04, '0, 2'b00);   // urgent flag without request
    step();
    expect_gnt("R2 idle no requests", 1'b0, 0, 1'b0);
  endtask

  task automatic t_urgent();
    // R3: urgent ch6 beats non-urgent ch5, direction differs from reset value
    drive(8'h60, 8'h40, 8'h40, 2'b00);
    step();
    expect_gnt("R3/R6 urgent over higher static priority", 1'b1, 6, 1'b1);
    // R3: stray urgent flag on idle ch2 has no effect
    drive(8'h20, 8'h04, 8'h00, 2'b00);
    step();
    expect_gnt("R3/R6 urgent flag without request ignored", 1'b1, 5, 1'b0);
  endtask

  task automatic t_urgent_dir();
    // last dir now 0 (ch5). ch1 urgent dir1, ch3 urgent dir0 -> ch3
    drive(8'h0A, 8'h0A, 8'h02, 2'b00);
    step();
    expect_gnt("R4 urgent pair, match dir0 beats lower index", 1'b1, 3, 1'b1);
    // set last dir to 1 via ch1
    drive(8'h02, 8'h02, 8'h02, 2'b00);
    step();
    expect_gnt("R4 single urgent ch1", 1'b1, 1, 1'b1);
    // ch1 urgent dir0, ch3 urgent dir1, last dir 1 -> ch3
    drive(8'h0A, 8'h0A, 8'h08, 2'b00);
    step();
    expect_gnt("R4 urgent pair, match dir1 beats lower index", 1'b1, 3, 1'b1);
    // same pattern again, last dir still 1 -> ch3
    step();
    expect_gnt("R4 direction remembered", 1'b1, 3, 1'b1);
  endtask

  task automatic t_normal();
    // last dir 1. ch2 dir0, ch4 dir1, no urgency -> ch4
    drive(8'h14, 8'h00, 8'h10, 2'b00);
    step();
    expect_gnt("R5 direction tie-break without urgency", 1'b1, 4, 1'b0);
    // ch2 and ch5 both dir1 -> ch2
    drive(8'h24, 8'h00, 8'h24, 2'b00);
    step();
    expect_gnt("R5 lowest index among equal match", 1'b1, 2, 1'b0);
  endtask

  task automatic t_class();
    drive(8'h80, 8'h00, 8'h80, 2'b11);
    step();
    expect_gnt("R7 peripheral beats streams", 1'b1, 7, 1'b0);
    drive(8'h00, 8'h00, 8'h00, 2'b11);
    step();
    expect_gnt("R7/R8 stream when peripherals idle", 1'b1, S0, 1'b0);
  endtask

  task automatic t_fixed();
    for (int k = 0; k < 4; k++) begin
      step();
      expect_gnt("R8 period zero keeps stream 0", 1'b1, S0, 1'b0);
    end
    drive('0, '0, '0, 2'b10);
    step();
    expect_gnt("R8 stream 1 alone", 1'b1, S1, 1'b0);
  endtask

  task automatic t_rr();
    drive('0, '0, '0, 2'b00);
    rr_period = 8'd3;
    step();
    drive('0, '0, '0, 2'b11);
    for (int k = 0; k < 3; k++) begin
      step();
      expect_gnt("R9 holder stream 0 keeps P grants", 1'b1, S0, 1'b0);
    end
    // holder now stream 1; only stream 0 ready
    drive('0, '0, '0, 2'b01);
    step();
    expect_gnt("R10 holder absent, other granted", 1'b1, S0, 1'b0);
    drive('0, '0, '0, 2'b11);
    for (int k = 0; k < 3; k++) begin
      step();
      expect_gnt("R9/R10 stream 1 gets full P after skip", 1'b1, S1, 1'b0);
    end
    step();
    expect_gnt("R9 hand-off back to stream 0", 1'b1, S0, 1'b0);
    // count is 1 for stream 0; change period to 2 -> clear
    step();
    expect_gnt("R9 stream 0 second grant", 1'b1, S0, 1'b0);
    rr_period = 8'd2;
    step();
    expect_gnt("R11 grant during period change", 1'b1, S0, 1'b0);
    for (int k = 0; k < 2; k++) begin
      step();
      expect_gnt("R11 fresh count after change", 1'b1, S0, 1'b0);
    end
    step();
    expect_gnt("R11 hand-off after new period", 1'b1, S1, 1'b0);
    drive('0, '0, '0, 2'b00);
    step();
    expect_gnt("R2 idle after streams", 1'b0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset_idle();
    t_urgent();
    t_urgent_dir();
    t_normal();
    t_class();
    t_fixed();
    t_rr();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule